// File: doc/BRIEF.md
# Per-Bit Set Frequency Tally

This block gathers bit-level statistics over a stream of sample words. A run starts with a one-cycle start strobe, which also supplies the number of samples to gather. During the run, one counter per bit position counts how many accepted samples had that bit set. Once the programmed number of samples has been accepted, the run stops and a done flag is raised.

The results are read through an indexed port. The caller presents a bit position and, one clock later, receives two values for that position: the raw tally and the absolute distance between the tally and half the trial count. An unbiased source should give distances that are small compared with the trial count. Reading can go on during a run to watch the live counts.

Top module: `bit_tally_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `done` is 0, `rd_tally` and `rd_dev` are 0, and every tally is 0.
- R2: A cycle with `start` high clears every tally to zero, clears `done`, and latches `trial_count` and the midpoint floor(`trial_count`/2) for the new run.
- R3: Each accepted sample adds exactly one to the tally of every bit position where the sample holds a 1. Positions holding a 0 are left unchanged.
- R4: A sample is accepted only when `sample_valid` is high, a run is in progress and `start` is low. A valid sample offered before any start, or after the run has completed, changes no tally.
- R5: A run ends when `trial_count` samples have been accepted. `done` reads 1 from the clock edge that accepts the final sample and stays 1 until the next start. It is 0 while the run is still short of its count.
- R6: A start with `trial_count` equal to 0 sets `done` at that same edge and leaves every tally at 0.
- R7: `rd_idx` selects a bit position, where 0 is the least significant bit of `sample`. `rd_tally` and `rd_dev` are registered and show that position one clock edge after `rd_idx` is presented.
- R8: `rd_dev` equals |tally − floor(trial_count/2)|. For an odd count the midpoint rounds down.
- R9: A start during a run restarts the run from zero. A valid sample in the same cycle as `start` is discarded.
- R10: Tallies are `CNT_W` bits wide (16 by default). A run of 2^`CNT_W`−1 samples that are all ones ends with every tally at that value and no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that begins a run |
| trial_count | input | CNT_W | Number of samples in the run, latched at start |
| sample | input | WORD_W | Sample word |
| sample_valid | input | 1 | Qualifies `sample` |
| done | output | 1 | High once the run has completed |
| rd_idx | input | IDX_W | Bit position to read out |
| rd_tally | output | CNT_W | Tally for the selected position |
| rd_dev | output | CNT_W | Absolute deviation of the tally from the midpoint |

## Verification
Two events can land in the same cycle: a start strobe and a valid sample. They meet both when a run is restarted part-way through and when the first run begins. The bench raises `start` and `sample_valid` together with an all-ones word, then reads every position and expects zero tallies. It also restarts a run part-way through and checks that the count begins afresh from the new strobe. The bench offers surplus samples after `done` and confirms that the read-back values stay the same.

// File: rtl/tally_pkg.sv
package tally_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } run_state_t;
endpackage

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] trial_count,
  input  logic             sample_valid,
  output logic             accept,
  output logic             clear,
  output logic             done,
  output logic [CNT_W-1:0] midpoint
);
  run_state_t       state;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] seen;
  logic [CNT_W-1:0] seen_next;

  assign clear     = start;
  assign accept    = sample_valid && (state == ST_RUN) && !start;
  assign seen_next = seen + 1'b1;
  assign done      = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      target   <= '0;
      seen     <= '0;
      midpoint <= '0;
    end else if (start) begin
      target   <= trial_count;
      midpoint <= trial_count >> 1;
      seen     <= '0;
      state    <= (trial_count == '0) ? ST_DONE : ST_RUN;
    end else if (accept) begin
      seen <= seen_next;
      if (seen_next == target) state <= ST_DONE;
    end
  end

  // R5: while running the accepted count stays below the target
  assert_seen_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (seen < target));

  // R5: done holds until a new start
  assert_done_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R2: a start restarts the accepted count
  assert_start_rearm_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> (seen == '0) && (midpoint == ($past(trial_count) >> 1)));
endmodule

// File: rtl/tally_bank.sv
module tally_bank #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         accept,
  input  logic [WORD_W-1:0]            sample,
  output logic [WORD_W-1:0][CNT_W-1:0] tallies
);
  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear) tallies[g] <= '0;
      else if (accept && sample[g]) tallies[g] <= tallies[g] + 1'b1;
    end

    // R3: without a clear a counter advances by zero or one per cycle
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
      !clear |=> (tallies[g] == $past(tallies[g])) ||
                 (tallies[g] == $past(tallies[g]) + 1'b1));

    // R4: without an accepted sample a counter holds
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!accept && !clear) |=> $stable(tallies[g]));
  end
endmodule

// File: rtl/tally_readout.sv
module tally_readout #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [WORD_W-1:0][CNT_W-1:0] tallies,
  input  logic [CNT_W-1:0]             midpoint,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [CNT_W-1:0]             rd_tally,
  output logic [CNT_W-1:0]             rd_dev
);
  logic [CNT_W-1:0] sel;
  logic [CNT_W-1:0] gap;

  always_comb begin
    sel = '0;
    for (int k = 0; k < WORD_W; k++)
      if (rd_idx == IDX_W'(k)) sel = tallies[k];
    gap = (sel >= midpoint) ? (sel - midpoint) : (midpoint - sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tally <= '0;
      rd_dev   <= '0;
    end else begin
      rd_tally <= sel;
      rd_dev   <= gap;
    end
  end

  // R8: the deviation and the tally sum back to the midpoint or differ by it
  assert_dev_consistent_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((rd_tally + rd_dev == $past(midpoint)) ||
              (rd_tally - rd_dev == $past(midpoint))));
endmodule

// File: rtl/bit_tally_unit.sv
module bit_tally_unit #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  trial_count,
  input  logic [WORD_W-1:0] sample,
  input  logic              sample_valid,
  output logic              done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  rd_tally,
  output logic [CNT_W-1:0]  rd_dev
);
  logic                         accept;
  logic                         clear;
  logic [CNT_W-1:0]             midpoint;
  logic [WORD_W-1:0][CNT_W-1:0] tallies;

  tally_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .trial_count(trial_count),
    .sample_valid(sample_valid), .accept(accept), .clear(clear),
    .done(done), .midpoint(midpoint)
  );

  tally_bank #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .clear(clear), .accept(accept),
    .sample(sample), .tallies(tallies)
  );

  tally_readout #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_rd (
    .clk(clk), .rst(rst), .tallies(tallies), .midpoint(midpoint),
    .rd_idx(rd_idx), .rd_tally(rd_tally), .rd_dev(rd_dev)
  );

  // R5: done can only rise after a run or a start
  assert_done_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(start) || $past(accept)));

  // R4: nothing is accepted while done is set and no start is given
  assert_no_accept_after_done_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |-> !accept);
endmodule

// File: tb/bit_tally_unit_bench.sv
`timescale 1ns/1ps
module bit_tally_unit_bench;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  trial_count = '0;
  logic [WORD_W-1:0] sample = '0;
  logic              sample_valid = 1'b0;
  logic              done;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [CNT_W-1:0]  rd_tally;
  logic [CNT_W-1:0]  rd_dev;

  always #2.5 clk = ~clk;

  bit_tally_unit #(.WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_bit_tally_unit (
    .clk(clk), .rst(rst), .start(start), .trial_count(trial_count),
    .sample(sample), .sample_valid(sample_valid), .done(done),
    .rd_idx(rd_idx), .rd_tally(rd_tally), .rd_dev(rd_dev)
  );

  int vectors = 0;
  int fails   = 0;
  int exp_t [WORD_W];
  int target  = 0;
  int acc     = 0;
  bit running = 1'b0;
  logic [31:0] rng = 32'h1234_5678;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic begin_run(input int n, input bit also_valid);
    trial_count  = CNT_W'(n);
    start        = 1'b1;
    sample       = '1;
    sample_valid = also_valid;
    @(negedge clk);
    start = 1'b0;
    sample_valid = 1'b0;
    for (int b = 0; b < WORD_W; b++) exp_t[b] = 0;
    target = n; acc = 0; running = (n != 0);
  endtask

  task automatic push(input logic [31:0] w, input bit v);
    sample = w; sample_valid = v;
    @(negedge clk);
    if (v && running && acc < target) begin
      for (int b = 0; b < WORD_W; b++) exp_t[b] += int'(w[b]);
      acc++;
      if (acc == target) running = 1'b0;
    end
    sample_valid = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < WORD_W; i++) begin
      int mid = target / 2;
      int dv  = (exp_t[i] >= mid) ? exp_t[i] - mid : mid - exp_t[i];
      rd_idx = IDX_W'(i);
      @(negedge clk);
      chk({tag, " R7 tally"}, int'(rd_tally), exp_t[i]);
      chk({tag, " R8 dev"}, int'(rd_dev), dv);
    end
  endtask

  // Full run with random words, occasional idle cycles and a done-timing check
  task automatic random_run(input int n, input string tag);
    begin_run(n, 1'b0);
    while (acc < n) begin
      rng = next_rng(rng);
      if (rng[3:0] == 4'h0) push(rng, 1'b0);
      if (acc == n - 1) chk({tag, " R5 done low before last"}, int'(done), 0);
      push(rng, 1'b1);
    end
    chk({tag, " R5 done after last"}, int'(done), 1);
    read_all(tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < WORD_W; b++) exp_t[b] = 0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(done), 0);
    chk("R1 rd_tally in reset", int'(rd_tally), 0);
    rst = 1'b0;
    chk("R1 done after reset", int'(done), 0);
    // R4: valid samples before any start are ignored
    push('1, 1'b1);
    push('1, 1'b1);
    read_all("R1 R4 pre-start");

    // R6: zero-length run
    begin_run(0, 1'b0);
    chk("R6 done after zero-length start", int'(done), 1);
    read_all("R6 zero run");

    // R3: walking ones, each bit once
    begin_run(WORD_W, 1'b0);
    for (int i = 0; i < WORD_W; i++) push(32'h1 << i, 1'b1);
    chk("R5 done walking", int'(done), 1);
    read_all("R3 walking ones");

    // R4: surplus samples after done leave tallies unchanged
    push('1, 1'b1);
    push(32'h5555_5555, 1'b1);
    chk("R5 done holds", int'(done), 1);
    read_all("R4 after done");

    // R3, R8: short runs of every length 1..9 (odd midpoints round down)
    for (int n = 1; n < 10; n++) random_run(n, "R3 R8 sweep");

    // R9: restart mid-run, with a valid all-ones word beside the start
    begin_run(5, 1'b0);
    push(32'hFFFF_0000, 1'b1);
    push(32'h0000_FFFF, 1'b1);
    begin_run(3, 1'b1);
    chk("R9 done cleared by restart", int'(done), 0);
    read_all("R9 R2 start with valid");
    push(32'hA5A5_A5A5, 1'b1);
    push(32'h0F0F_0F0F, 1'b1);
    push(32'hFFFF_FFFF, 1'b1);
    chk("R9 done after restart run", int'(done), 1);
    read_all("R9 restarted run");

    // R8: default-size run of 10000, midpoint 5000
    random_run(10000, "R8 default run");

    // R10: maximum-length run of all ones
    begin_run(65535, 1'b0);
    for (int i = 0; i < 65535; i++) push('1, 1'b1);
    chk("R10 done at max", int'(done), 1);
    read_all("R10 max run");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule